// File: doc/BRIEF.md
# Nine-bit three-wire display serial link

This block moves single bytes to a display controller over a serial link whose words are nine bits wide. The top bit of each word tells the controller whether the remaining eight bits are a command code or a parameter. A host presents one byte at a time on a valid/ready handshake. Each byte becomes one framed word, with chip select low for the frame. The serial clock idles low. Output data changes on the falling clock edge, and input data is sampled on the rising edge.

A request can also be marked as an identification read. In that case the block sends the request byte as a command word. It then clocks a nine-bit filler frame, whose input it throws away, so that the controller gets one spare clock before its reply. Finally it clocks an eight-bit frame and keeps those eight input bits as the identification byte. The serial clock rate comes from the system clock through a divider input. Software picks the divider value for roughly 1 MHz.

Top module: `nine_bit_spi_ser`

## Requirements
- R1: After reset csN is 1, sck is 0, busy is 0, reqReady is 1, done is 0 and idByte is 0.
- R2: A write request with reqParam=0 and reqRead=0 produces one frame of exactly 9 sck rising edges. The frame is sent MSB first, with bit 8 = 0 and bits 7..0 = reqByte.
- R3: A write request with reqParam=1 (reqRead=0) produces one 9-bit frame with bit 8 = 1 and bits 7..0 = reqByte. Back-to-back requests each produce their own frame, in order.
- R4: sck is 0 whenever csN is 1 and at the moment csN falls. mosi does not change while sck is high, so it changes only on falling edges or while deselected.
- R5: One sck half-period lasts clkDiv+1 system cycles. The first rising edge comes clkDiv+1 cycles after csN falls, and successive rising edges are 2*(clkDiv+1) cycles apart.
- R6: csN stays low for a whole frame. Between two frames it stays high for at least one sck period, 2*(clkDiv+1) cycles. It is high whenever busy is 0.
- R7: A request with reqRead=1 produces three frames in order. The first is a 9-bit command word with bit 8 = 0 and bits 7..0 = reqByte; reqParam is ignored. The second is a 9-bit filler frame, and the third is an 8-bit frame. mosi is 0 throughout the last two frames.
- R8: At the end of a read, idByte holds the 8 miso bits sampled on the rising edges of the 8-bit frame, first sample in bit 7. The bits sampled during the filler frame have no effect on idByte.
- R9: A request is accepted on a clock edge where reqValid and reqReady are both 1. busy is 1 from the next cycle until the request finishes, reqReady equals the inverse of busy, and busy is 0 in the cycle done is 1.
- R10: done is a one-cycle pulse at the end of every request. idByte changes only at the end of a read and is unchanged by write requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clkDiv | input | DIV_W | Half-period of sck minus one, in system cycles |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqRead | input | 1 | 1: identification read, 0: single write |
| reqParam | input | 1 | For writes, 1 marks the byte as a parameter |
| reqByte | input | DATA_W | Command code or parameter byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| idByte | output | DATA_W | Byte captured by the last read |
| csN | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the controller |
| miso | input | 1 | Serial data from the controller |

## Verification
The assertions rely on three assumptions about the inputs. clkDiv is held steady while busy is high. The request fields matter only on the accepting edge. miso is settled before each rising sck edge, because the controller changes it after a falling edge or after select. The bench changes clkDiv only between requests, after done has been seen. It drives request fields half a cycle away from the accepting edge and drops reqValid right after acceptance. Its controller model updates miso only at the sample point that follows a falling sck or a falling csN. Frame-gap checks apply only between frames sent with the same divider value.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic [1:0] {
    FR_WRITE = 2'd0,
    FR_FILL  = 2'd1,
    FR_REPLY = 2'd2
  } frameSel_e;

  typedef struct packed {
    logic      loadFrame;
    frameSel_e frameSel;
    logic      shiftOut;
    logic      sampleIn;
    logic      tickClr;
    logic      captureId;
  } ctlStrobes_t;

endpackage

// File: rtl/nbs_datapath.sv
module nbs_datapath
  import nbs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              reqParam,
  input  logic              reqRead,
  input  logic [DATA_W-1:0] reqByte,
  input  ctlStrobes_t       strb,
  input  logic              miso,
  output logic              tick,
  output logic              lastBit,
  output logic              mosi,
  output logic [DATA_W-1:0] idByte
);
  localparam int WORD_W = DATA_W + 1;
  localparam int BCNT_W = $clog2(WORD_W + 1);

  logic [DIV_W-1:0]  divCnt;
  logic [WORD_W-1:0] txReg;
  logic [DATA_W-1:0] rxReg;
  logic [BCNT_W-1:0] bitsLeft;
  logic              wordFlag;

  assign tick     = (divCnt == clkDiv);
  assign lastBit  = (bitsLeft == BCNT_W'(1));
  assign mosi     = txReg[WORD_W-1];
  assign wordFlag = reqParam & ~reqRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (strb.tickClr || tick) divCnt <= '0;
    else divCnt <= divCnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg    <= '0;
      bitsLeft <= '0;
    end else if (strb.loadFrame) begin
      case (strb.frameSel)
        FR_WRITE: begin
          txReg    <= {wordFlag, reqByte};
          bitsLeft <= BCNT_W'(WORD_W);
        end
        FR_FILL: begin
          txReg    <= '0;
          bitsLeft <= BCNT_W'(WORD_W);
        end
        default: begin
          txReg    <= '0;
          bitsLeft <= BCNT_W'(DATA_W);
        end
      endcase
    end else if (strb.shiftOut) begin
      txReg    <= {txReg[WORD_W-2:0], 1'b0};
      bitsLeft <= bitsLeft - BCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxReg <= '0;
    else if (strb.sampleIn) rxReg <= {rxReg[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idByte <= '0;
    else if (strb.captureId) idByte <= rxReg;
  end

endmodule

// File: rtl/nbs_control.sv
module nbs_control
  import nbs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqRead,
  input  logic        tick,
  input  logic        lastBit,
  output logic        reqReady,
  output logic        busy,
  output logic        done,
  output logic        csN,
  output logic        sck,
  output ctlStrobes_t strb
);
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_LOW   = 3'd1,
    S_HIGH  = 3'd2,
    S_TRAIL = 3'd3,
    S_GAP1  = 3'd4,
    S_GAP2  = 3'd5
  } state_e;

  state_e     st, stNext;
  logic       isRead, isReadNext;
  logic [1:0] frameIdx, frameIdxNext;
  logic       doneNext;

  assign reqReady = ~busy;

  always_comb begin
    strb         = '0;
    stNext       = st;
    isReadNext   = isRead;
    frameIdxNext = frameIdx;
    doneNext     = 1'b0;
    case (st)
      S_IDLE: if (reqValid) begin
        strb.loadFrame = 1'b1;
        strb.frameSel  = FR_WRITE;
        strb.tickClr   = 1'b1;
        isReadNext     = reqRead;
        frameIdxNext   = 2'd0;
        stNext         = S_LOW;
      end
      S_LOW: if (tick) begin
        strb.sampleIn = 1'b1;
        stNext        = S_HIGH;
      end
      S_HIGH: if (tick) begin
        if (lastBit) stNext = S_TRAIL;
        else begin
          strb.shiftOut = 1'b1;
          stNext        = S_LOW;
        end
      end
      S_TRAIL: if (tick) stNext = S_GAP1;
      S_GAP1:  if (tick) stNext = S_GAP2;
      S_GAP2: if (tick) begin
        if (isRead && frameIdx != 2'd2) begin
          strb.loadFrame = 1'b1;
          strb.frameSel  = (frameIdx == 2'd0) ? FR_FILL : FR_REPLY;
          frameIdxNext   = frameIdx + 2'd1;
          stNext         = S_LOW;
        end else begin
          strb.captureId = isRead;
          doneNext       = 1'b1;
          stNext         = S_IDLE;
        end
      end
      default: stNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= S_IDLE;
      isRead   <= 1'b0;
      frameIdx <= 2'd0;
      busy     <= 1'b0;
      done     <= 1'b0;
      csN      <= 1'b1;
      sck      <= 1'b0;
    end else begin
      st       <= stNext;
      isRead   <= isReadNext;
      frameIdx <= frameIdxNext;
      busy     <= (stNext != S_IDLE);
      done     <= doneNext;
      csN      <= !(stNext == S_LOW || stNext == S_HIGH || stNext == S_TRAIL);
      sck      <= (stNext == S_HIGH);
    end
  end

endmodule

// File: rtl/nine_bit_spi_ser.sv
module nine_bit_spi_ser
  import nbs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqRead,
  input  logic              reqParam,
  input  logic [DATA_W-1:0] reqByte,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] idByte,
  output logic              csN,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  ctlStrobes_t strb;
  logic        tick;
  logic        lastBit;

  nbs_control ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .tick(tick), .lastBit(lastBit), .reqReady(reqReady), .busy(busy),
    .done(done), .csN(csN), .sck(sck), .strb(strb)
  );

  nbs_datapath #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dp_i (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .reqParam(reqParam),
    .reqRead(reqRead), .reqByte(reqByte), .strb(strb), .miso(miso),
    .tick(tick), .lastBit(lastBit), .mosi(mosi), .idByte(idByte)
  );

endmodule

// File: rtl/nbs_checker.sv
module nbs_checker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic busy,
  input logic done,
  input logic csN,
  input logic sck,
  input logic mosi
);
  p_sck_low_deselected_r4: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  p_mosi_steady_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));

  p_idle_deselect_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  p_accept_sets_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> busy);

  p_done_clears_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind nine_bit_spi_ser nbs_checker chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .busy(busy), .done(done), .csN(csN), .sck(sck), .mosi(mosi)
);

// File: tb/nine_bit_spi_ser_tb_top.sv
module nine_bit_spi_ser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;

  logic clk = 0;
  logic rstN = 0;
  logic [DIV_W-1:0] clkDiv = 8'd3;
  logic reqValid = 0, reqRead = 0, reqParam = 0;
  logic [DATA_W-1:0] reqByte = '0;
  logic reqReady, busy, done, csN, sck, mosi;
  logic [DATA_W-1:0] idByte;
  logic miso = 0;

  int checks = 0;
  int errors = 0;

  nine_bit_spi_ser #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .reqValid(reqValid),
    .reqReady(reqReady), .reqRead(reqRead), .reqParam(reqParam),
    .reqByte(reqByte), .busy(busy), .done(done), .idByte(idByte),
    .csN(csN), .sck(sck), .mosi(mosi), .miso(miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Controller model and frame monitor
  int fBits[64];
  int fVal[64];
  int fDiv[64];
  int nf = 0;
  int frBits, frVal, riseGap, gapCnt, curFrame, misoPos;
  int fillFrame = -1, replyFrame = -1;
  logic [7:0] replyId = 8'h00;
  logic csPrev = 1, sckPrev = 0, mosiPrev = 0;

  function automatic logic driveBit(input int frame, input int pos);
    if (frame == replyFrame && pos >= 0) return replyId[pos];
    if (frame == fillFrame) return 1'b1;
    return 1'b0;
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      if (csPrev && !csN) begin
        chk(sck == 1'b0, "R4", "sck at select", int'(sck), 0);
        if (nf > 0 && fDiv[(nf-1) % 64] == int'(clkDiv))
          chk(gapCnt >= 2*(int'(clkDiv)+1), "R6", "deselect gap",
              gapCnt, 2*(int'(clkDiv)+1));
        frBits = 0; frVal = 0; riseGap = 0; curFrame = nf; misoPos = 7;
        miso = driveBit(curFrame, misoPos);
      end
      if (!csN && !sckPrev && sck) begin
        chk(riseGap == ((frBits == 0) ? int'(clkDiv)+1 : 2*(int'(clkDiv)+1)),
            "R5", "rise spacing", riseGap,
            (frBits == 0) ? int'(clkDiv)+1 : 2*(int'(clkDiv)+1));
        frVal = ((frVal << 1) | int'(mosi)) & 'h1FF;
        frBits++;
        riseGap = 0;
      end
      if (!csN && sckPrev && !sck) begin
        misoPos--;
        miso = driveBit(curFrame, misoPos);
      end
      if (sck && sckPrev && mosi !== mosiPrev)
        chk(0, "R4", "mosi moved while sck high", int'(mosi), int'(mosiPrev));
      if (csN && sck)
        chk(0, "R4", "sck high while deselected", 1, 0);
      if (!csPrev && csN) begin
        fBits[nf % 64] = frBits; fVal[nf % 64] = frVal;
        fDiv[nf % 64] = int'(clkDiv);
        nf++;
        gapCnt = 0;
      end
      if (csN) gapCnt++;
      riseGap++;
      csPrev = csN; sckPrev = sck; mosiPrev = mosi;
    end
  end

  task automatic runReq(input bit rd, input bit prm, input logic [7:0] b,
                        input string req);
    int n;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqRead = rd; reqParam = prm; reqByte = b;
    @(negedge clk);
    reqValid = 0; reqByte = 8'h00;
    chk(busy === 1'b1, "R9", "busy after accept", int'(busy), 1);
    chk(reqReady === 1'b0, "R9", "ready while busy", int'(reqReady), 0);
    n = 0;
    while (done !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1 && busy === 1'b0, "R9", {"end of request ", req},
        int'({done, busy}), 2);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done one cycle", int'(done), 0);
  endtask

  task automatic checkFrame(input int idx, input int bits, input int val,
                            input string req);
    chk(fBits[idx % 64] == bits, req, "frame bit count", fBits[idx % 64], bits);
    chk(fVal[idx % 64] == val, req, "frame value", fVal[idx % 64], val);
  endtask

  task automatic testReset;
    chk(csN === 1 && sck === 0, "R1", "serial pins at reset", int'({csN, sck}), 2);
    chk(busy === 0 && reqReady === 1 && done === 0, "R1", "handshake at reset",
        int'({busy, reqReady, done}), 2);
    chk(idByte === 8'h00, "R1", "idByte at reset", int'(idByte), 0);
  endtask

  task automatic testCmdWrite;
    int base = nf;
    runReq(0, 0, 8'h3A, "R2");
    chk(nf - base == 1, "R2", "frame count", nf - base, 1);
    checkFrame(base, 9, 'h03A, "R2");
  endtask

  task automatic testParamStream;
    int base = nf;
    runReq(0, 1, 8'hA5, "R3");
    runReq(0, 1, 8'h5A, "R3");
    runReq(0, 1, 8'hFF, "R3");
    chk(nf - base == 3, "R3", "frame count", nf - base, 3);
    checkFrame(base,     9, 'h1A5, "R3");
    checkFrame(base + 1, 9, 'h15A, "R3");
    checkFrame(base + 2, 9, 'h1FF, "R3");
  endtask

  task automatic testRead(input logic [7:0] id);
    int base = nf;
    replyId = id; fillFrame = base + 1; replyFrame = base + 2;
    runReq(1, 1, 8'h04, "R7");
    chk(nf - base == 3, "R7", "read frame count", nf - base, 3);
    checkFrame(base,     9, 'h004, "R7");
    checkFrame(base + 1, 9, 'h000, "R7");
    checkFrame(base + 2, 8, 'h000, "R7");
    chk(idByte === id, "R8", "captured id", int'(idByte), int'(id));
    fillFrame = -1; replyFrame = -1;
  endtask

  task automatic testWriteKeepsId(input logic [7:0] id);
    runReq(0, 1, 8'h11, "R10");
    chk(idByte === id, "R10", "idByte after write", int'(idByte), int'(id));
    runReq(0, 0, 8'h29, "R10");
    chk(idByte === id, "R10", "idByte after command", int'(idByte), int'(id));
  endtask

  task automatic setDiv(input int d);
    @(negedge clk);
    clkDiv = DIV_W'(d);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "R9", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1;
    @(negedge clk);
    testReset();
    setDiv(3);
    testCmdWrite();
    testParamStream();
    setDiv(2);
    testRead(8'hC3);
    testWriteKeepsId(8'hC3);
    setDiv(0);
    testCmdWrite();
    testRead(8'h5A);
    setDiv(7);
    testParamStream();
    testRead(8'h81);
    testWriteKeepsId(8'h81);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule